// File: doc/BRIEF.md
# Programmable Address Generator with Zero-Overhead Loops

This block produces the address stream for one data memory of a datapath. It holds a short program in a 64-word, 16-bit instruction store that is loaded through a plain write port. Once started, it executes one instruction per clock. Update instructions modify one of eight address registers and present the result, optionally bit-reversed, as the memory address in the next cycle.

A loop sequencer keeps up to four nested loop contexts on a small LIFO. A push instruction opens a loop: it gives the body length (1 to 8 instructions, which directly follow the push) and an iteration count. When the last body instruction executes, the program counter either returns to the body start in the same cycle, or pops the context and falls through. No cycle is lost on a branch. Loops that share their last instruction are closed together in one cycle.

A halt instruction ends execution and raises `done` until the next start. The registers and the bit-reverse width keep their values from one run to the next.

Top module: `agu_top`

## Requirements
- R1: After reset, `busy`, `done`, `addr_vld` and `lifo_err` are 0, `lifo_empty` is 1, `addr_o` is 0, all eight registers are 0 and the bit-reverse width is 6.
- R2: A `start` pulse taken while not running clears the program counter to 0, empties the LIFO, clears `lifo_err` and raises `busy`. A `start` pulse taken while running is ignored. Instruction word bits [15:13] give the opcode. HALT (5) drops `busy` and holds `done` at 1 until the next start.
- R3: NOP (opcode 0, and also 6 or 7) only advances the program counter. LDI (opcode 2) writes the zero-extended bits [9:0] into the register selected by bits [12:10].
- R4: UPD (opcode 1) has these fields: destination register in [12:10], second operand register in [9:7], operation in [6:4], wrap flag in [3] and reverse flag in [2]. The operations are pass=0, A+B=1, A+1=2, A−B=3, A−1=4, and 5 to 7 act as pass. All arithmetic is modulo 2^16. The result is written back, and the address appears on `addr_o` with `addr_vld` high in the following cycle.
- R5: With the wrap flag set, R6 is the base and R7 the size. A result at or above base+size has size subtracted once. Otherwise, a result below base has size added once.
- R6: With the reverse flag set, the low W bits of the emitted address are mirrored and the upper bits pass unchanged. The stored register keeps the unreversed value. CFG (opcode 4) sets W from bits [2:0]: 0 acts as 1, and 7 acts as 6.
- R7: PUSH (opcode 3) uses bits [10:8] as body length minus one and bits [7:0] as the iteration count, where 0 counts as 1. The body runs the given number of times and then execution continues after it.
- R8: Loop branches cost no cycles. From start to done, `busy` stays high for exactly the number of instructions executed, including the HALT.
- R9: Up to four loops nest. When several open loops end on the same instruction, every finished one is popped in that cycle, and the innermost unfinished one branches.
- R10: A PUSH onto a full LIFO is ignored and sets `lifo_err`, which stays set until the next start.
- R11: `lifo_empty` is 1 exactly when no loop context is open. It returns to 1 once every opened loop has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 6 | Instruction store write address |
| prog_data | input | 16 | Instruction word to write |
| addr_o | output | 16 | Generated memory address |
| addr_vld | output | 1 | `addr_o` carries a new address this cycle |
| busy | output | 1 | Program running |
| done | output | 1 | Program reached HALT |
| lifo_empty | output | 1 | No loop context open |
| lifo_err | output | 1 | Sticky push-overflow flag |

## Verification
The hardest corner is several loops closing on one instruction. A sequencer that examines only the top context would fall out of the outer loop early, emit too few addresses and finish in too few cycles. Overflow is driven with a fifth nested push. A design that accepted it would repeat the inner body, and one that dropped the flag would leave `lifo_err` low. Wrap cases step just past both ends of the window, and reverse cases use narrow widths, so a wrong comparison or a mirrored stored register shows up as a wrong address. Random nested programs with zero iteration counts are compared address by address and cycle by cycle against a bench interpreter, and a start pulse mid-run catches a design that restarts.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AGU_AW     = 16;
    localparam int AGU_IW     = 16;
    localparam int AGU_PDEPTH = 64;
    localparam int AGU_LDEPTH = 4;
    localparam int AGU_NREG   = 8;
    localparam int AGU_CNTW   = 8;
    localparam int AGU_MAXBR  = 6;
    localparam int AGU_IMMW   = 10;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_UPD  = 3'd1,
        OP_LDI  = 3'd2,
        OP_PUSH = 3'd3,
        OP_CFG  = 3'd4,
        OP_HALT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        AL_PASS = 3'd0,
        AL_ADD  = 3'd1,
        AL_INC  = 3'd2,
        AL_SUB  = 3'd3,
        AL_DEC  = 3'd4
    } alu_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_e;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] dst;
        logic [2:0] srcb;
        logic [2:0] alu;
        logic       wrap;
        logic       rev;
        logic [1:0] spare;
    } upd_fmt_t;

    typedef struct packed {
        logic [2:0]          op;
        logic [2:0]          dst;
        logic [AGU_IMMW-1:0] imm;
    } ldi_fmt_t;

    typedef struct packed {
        logic [2:0]          op;
        logic [1:0]          spare;
        logic [2:0]          len_m1;
        logic [AGU_CNTW-1:0] count;
    } push_fmt_t;

    function automatic logic [2:0] clamp_brw(input logic [2:0] f);
        if (f == 3'd0)
            return 3'd1;
        if (f > 3'(AGU_MAXBR))
            return 3'(AGU_MAXBR);
        return f;
    endfunction
endpackage

// File: rtl/agu_addr_unit.sv
module agu_addr_unit
    import agu_pkg::*;
#(
    parameter int AW    = AGU_AW,
    parameter int NREG  = AGU_NREG,
    parameter int IMMW  = AGU_IMMW,
    parameter int MAXBR = AGU_MAXBR,
    localparam int RIW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_en,
    input  logic            ldi_en,
    input  logic            cfg_en,
    input  logic [RIW-1:0]  dst,
    input  logic [RIW-1:0]  srcb,
    input  logic [2:0]      alu,
    input  logic            wrap,
    input  logic            rev,
    input  logic [IMMW-1:0] imm,
    input  logic [2:0]      brw_in,
    output logic [AW-1:0]   addr_o,
    output logic            addr_vld
);
    localparam int BASE_IX = NREG - 2;
    localparam int SIZE_IX = NREG - 1;

    logic [AW-1:0] rf [NREG];
    logic [2:0]    brw_q;
    logic [AW-1:0] opa, opb, raw, wrapped, revd, hi;

    always_comb begin
        opa = rf[dst];
        opb = rf[srcb];
        case (alu_e'(alu))
            AL_ADD:  raw = opa + opb;
            AL_INC:  raw = opa + AW'(1);
            AL_SUB:  raw = opa - opb;
            AL_DEC:  raw = opa - AW'(1);
            default: raw = opa;
        endcase
        hi      = rf[BASE_IX] + rf[SIZE_IX];
        wrapped = raw;
        if (wrap) begin
            if (raw >= hi)
                wrapped = raw - rf[SIZE_IX];
            else if (raw < rf[BASE_IX])
                wrapped = raw + rf[SIZE_IX];
        end
        revd = wrapped;
        for (int j = 0; j < MAXBR; j++) begin
            if (j < int'(brw_q))
                revd[j] = wrapped[int'(brw_q) - 1 - j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++)
                rf[i] <= '0;
            brw_q    <= 3'(MAXBR);
            addr_o   <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= upd_en;
            if (upd_en) begin
                rf[dst] <= wrapped;
                addr_o  <= rev ? revd : wrapped;
            end
            if (ldi_en)
                rf[dst] <= AW'(imm);
            if (cfg_en)
                brw_q <= brw_in;
        end
    end
endmodule

// File: rtl/agu_loopseq.sv
module agu_loopseq
    import agu_pkg::*;
#(
    parameter int PCW    = 6,
    parameter int LDEPTH = AGU_LDEPTH,
    parameter int CNTW   = AGU_CNTW,
    localparam int SPW   = $clog2(LDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [PCW-1:0]  pc,
    input  logic            push,
    input  logic [2:0]      len_m1,
    input  logic [CNTW-1:0] count,
    output logic [PCW-1:0]  pc_next,
    output logic            empty,
    output logic            overflow,
    output logic [SPW-1:0]  sp
);
    localparam int IXW = (LDEPTH > 1) ? $clog2(LDEPTH) : 1;

    logic [PCW-1:0]  end_q [LDEPTH];
    logic [3:0]      len_q [LDEPTH];
    logic [CNTW-1:0] tgt_q [LDEPTH];
    logic [CNTW-1:0] cnt_q [LDEPTH];
    logic [SPW-1:0]  sp_q, popn;
    logic [IXW-1:0]  bidx, ix;
    logic            brk, cont;
    logic [CNTW:0]   neff;

    assign sp       = sp_q;
    assign empty    = (sp_q == '0);
    assign overflow = step && push && (sp_q == SPW'(LDEPTH));

    always_comb begin
        pc_next = pc + PCW'(1);
        popn    = '0;
        brk     = 1'b0;
        bidx    = '0;
        ix      = '0;
        neff    = '0;
        cont    = !push;
        for (int i = 0; i < LDEPTH; i++) begin
            if (cont && (i < int'(sp_q))) begin
                ix   = IXW'(int'(sp_q) - 1 - i);
                neff = (tgt_q[ix] == '0) ? (CNTW+1)'(1) : {1'b0, tgt_q[ix]};
                if (end_q[ix] == pc) begin
                    if ({1'b0, cnt_q[ix]} + (CNTW+1)'(1) >= neff) begin
                        popn = popn + SPW'(1);
                    end else begin
                        brk     = 1'b1;
                        bidx    = ix;
                        pc_next = pc - PCW'(len_q[ix]) + PCW'(1);
                        cont    = 1'b0;
                    end
                end else begin
                    cont = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sp_q <= '0;
            for (int i = 0; i < LDEPTH; i++) begin
                end_q[i] <= '0;
                len_q[i] <= '0;
                tgt_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else if (step) begin
            if (push) begin
                if (sp_q != SPW'(LDEPTH)) begin
                    end_q[IXW'(sp_q)] <= pc + PCW'(len_m1) + PCW'(1);
                    len_q[IXW'(sp_q)] <= {1'b0, len_m1} + 4'd1;
                    tgt_q[IXW'(sp_q)] <= count;
                    cnt_q[IXW'(sp_q)] <= '0;
                    sp_q              <= sp_q + SPW'(1);
                end
            end else begin
                if (brk)
                    cnt_q[bidx] <= cnt_q[bidx] + CNTW'(1);
                sp_q <= sp_q - popn;
            end
        end
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int AW     = AGU_AW,
    parameter int IW     = AGU_IW,
    parameter int PDEPTH = AGU_PDEPTH,
    parameter int LDEPTH = AGU_LDEPTH,
    parameter int NREG   = AGU_NREG,
    localparam int PCW   = $clog2(PDEPTH),
    localparam int SPW   = $clog2(LDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           prog_we,
    input  logic [PCW-1:0] prog_addr,
    input  logic [IW-1:0]  prog_data,
    output logic [AW-1:0]  addr_o,
    output logic           addr_vld,
    output logic           busy,
    output logic           done,
    output logic           lifo_empty,
    output logic           lifo_err
);
    logic [IW-1:0]  imem [PDEPTH];
    logic [PCW-1:0] pc_q, pc_next;
    run_e           state_q;
    logic [IW-1:0]  instr;
    upd_fmt_t       uf;
    ldi_fmt_t       lf;
    push_fmt_t      pf;
    op_e            op;
    logic           exec, clear, halt, ovf;
    logic           upd_en, ldi_en, cfg_en, push_en;
    logic [SPW-1:0] lifo_sp;

    always_ff @(posedge clk) begin
        if (prog_we)
            imem[prog_addr] <= prog_data;
    end

    assign instr   = imem[pc_q];
    assign uf      = upd_fmt_t'(instr);
    assign lf      = ldi_fmt_t'(instr);
    assign pf      = push_fmt_t'(instr);
    assign op      = op_e'(uf.op);
    assign exec    = (state_q == ST_RUN);
    assign clear   = start && !exec;
    assign upd_en  = exec && (op == OP_UPD);
    assign ldi_en  = exec && (op == OP_LDI);
    assign cfg_en  = exec && (op == OP_CFG);
    assign push_en = exec && (op == OP_PUSH);
    assign halt    = exec && (op == OP_HALT);
    assign busy    = exec;
    assign done    = (state_q == ST_DONE);

    agu_addr_unit #(.AW(AW), .NREG(NREG), .IMMW(AGU_IMMW), .MAXBR(AGU_MAXBR)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .ldi_en   (ldi_en),
        .cfg_en   (cfg_en),
        .dst      (uf.dst),
        .srcb     (uf.srcb),
        .alu      (uf.alu),
        .wrap     (uf.wrap),
        .rev      (uf.rev),
        .imm      (lf.imm),
        .brw_in   (clamp_brw(instr[2:0])),
        .addr_o   (addr_o),
        .addr_vld (addr_vld)
    );

    agu_loopseq #(.PCW(PCW), .LDEPTH(LDEPTH), .CNTW(AGU_CNTW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .step     (exec && !halt),
        .pc       (pc_q),
        .push     (push_en),
        .len_m1   (pf.len_m1),
        .count    (pf.count),
        .pc_next  (pc_next),
        .empty    (lifo_empty),
        .overflow (ovf),
        .sp       (lifo_sp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            lifo_err <= 1'b0;
        end else if (clear) begin
            state_q  <= ST_RUN;
            pc_q     <= '0;
            lifo_err <= 1'b0;
        end else if (halt) begin
            state_q <= ST_DONE;
        end else if (exec) begin
            pc_q <= pc_next;
            if (ovf)
                lifo_err <= 1'b1;
        end
    end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int LDEPTH = 4,
    parameter int SPW    = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           addr_vld,
    input logic           lifo_empty,
    input logic           lifo_err,
    input logic [SPW-1:0] lifo_sp
);
    p_done_after_run_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    p_addr_from_run_r4: assert property (@(posedge clk) disable iff (rst)
        addr_vld |-> $past(busy));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (lifo_err && !start) |=> lifo_err);

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
        int'(lifo_sp) <= LDEPTH);

    p_empty_on_start_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (lifo_empty && !lifo_err));

    p_idle_no_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && !busy)) |=> !addr_vld);
endmodule

bind agu_top agu_chk #(.LDEPTH(LDEPTH), .SPW(SPW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .addr_vld   (addr_vld),
    .lifo_empty (lifo_empty),
    .lifo_err   (lifo_err),
    .lifo_sp    (lifo_sp)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;
    localparam int CLK_P = 10;
    localparam int MAXA  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [15:0] addr_o;
    logic        addr_vld, busy, done, lifo_empty, lifo_err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] prog     [64];
    logic [15:0] exp_addr [MAXA];
    logic [15:0] got_addr [MAXA];
    logic [15:0] mregs    [8];
    int          mbrw;
    int          exp_n, exp_cyc, got_n, got_cyc;
    bit          exp_err;

    always #(CLK_P/2) clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst(rst), .start(start), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .addr_o(addr_o),
        .addr_vld(addr_vld), .busy(busy), .done(done),
        .lifo_empty(lifo_empty), .lifo_err(lifo_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] e_upd(int d, int b, int alu, int w, int r);
        return {3'd1, 3'(d), 3'(b), 3'(alu), 1'(w), 1'(r), 2'b00};
    endfunction
    function automatic logic [15:0] e_ldi(int d, int imm);
        return {3'd2, 3'(d), 10'(imm)};
    endfunction
    function automatic logic [15:0] e_push(int m, int n);
        return {3'd3, 2'b00, 3'(m - 1), 8'(n)};
    endfunction
    function automatic logic [15:0] e_cfg(int w);
        return {3'd4, 10'd0, 3'(w)};
    endfunction
    function automatic logic [15:0] e_halt();
        return {3'd5, 13'd0};
    endfunction

    function automatic logic [15:0] mirror(logic [15:0] a, int w);
        logic [15:0] r = a;
        for (int j = 0; j < w; j++)
            r[j] = a[w - 1 - j];
        return r;
    endfunction

    // bench interpreter built from the requirements
    task automatic iss();
        int pc = 0, sp = 0;
        int s_start [4], s_end [4], s_rem [4];
        exp_n = 0; exp_cyc = 0; exp_err = 0;
        while (exp_cyc < 20000) begin
            logic [15:0] w = prog[pc];
            int nxt = (pc + 1) % 64;
            exp_cyc++;
            if (w[15:13] == 3'd5)
                break;
            if (w[15:13] == 3'd3) begin
                if (sp == 4) exp_err = 1;
                else begin
                    s_start[sp] = pc + 1;
                    s_end[sp]   = (pc + int'(w[10:8]) + 1) % 64;
                    s_rem[sp]   = (w[7:0] == 0) ? 1 : int'(w[7:0]);
                    sp++;
                end
                pc = nxt;
                continue;
            end
            case (w[15:13])
                3'd1: begin
                    logic [15:0] a = mregs[w[12:10]];
                    logic [15:0] b = mregs[w[9:7]];
                    logic [15:0] r, hi;
                    case (w[6:4])
                        3'd1: r = a + b;
                        3'd2: r = a + 16'd1;
                        3'd3: r = a - b;
                        3'd4: r = a - 16'd1;
                        default: r = a;
                    endcase
                    if (w[3]) begin
                        hi = mregs[6] + mregs[7];
                        if (r >= hi) r = r - mregs[7];
                        else if (r < mregs[6]) r = r + mregs[7];
                    end
                    mregs[w[12:10]] = r;
                    exp_addr[exp_n] = w[2] ? mirror(r, mbrw) : r;
                    if (exp_n < MAXA - 1) exp_n++;
                end
                3'd2: mregs[w[12:10]] = {6'd0, w[9:0]};
                3'd4: mbrw = (w[2:0] == 0) ? 1 : (w[2:0] > 6 ? 6 : int'(w[2:0]));
                default: ;
            endcase
            while (sp > 0 && pc == s_end[sp-1]) begin
                s_rem[sp-1]--;
                if (s_rem[sp-1] > 0) begin
                    nxt = s_start[sp-1];
                    break;
                end
                sp--;
            end
            pc = nxt;
        end
    endtask

    task automatic load();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run(input bit poke);
        int guard = 0;
        got_n = 0; got_cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && guard < 30000) begin
            if (busy) got_cyc++;
            if (addr_vld && got_n < MAXA) begin
                got_addr[got_n] = addr_o;
                got_n++;
            end
            if (poke && got_cyc == 4) start = 1'b1;
            else start = 1'b0;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(guard < 30000, "R2 watchdog run", guard, 0);
    endtask

    task automatic compare(input string tag);
        check(got_n == exp_n, {tag, " R4 address count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_addr[i] == exp_addr[i], {tag, " R4 address"}, got_addr[i], exp_addr[i]);
        check(got_cyc == exp_cyc, {tag, " R8 busy cycles"}, got_cyc, exp_cyc);
        check(done && !busy, {tag, " R2 done after halt"}, done, 1);
        check(lifo_err == exp_err, {tag, " R10 error flag"}, lifo_err, exp_err);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 16'h0000;
    endtask

    task automatic gen_random();
        int p = 0, d, u;
        int ml [5], tr [5];
        clear_prog();
        prog[p++] = e_ldi(6, $urandom_range(0, 200));
        prog[p++] = e_ldi(7, $urandom_range(1, 16));
        for (int r = 0; r < 6; r++) prog[p++] = e_ldi(r, $urandom_range(0, 1023));
        prog[p++] = e_cfg($urandom_range(0, 7));
        d = $urandom_range(1, 4);
        u = $urandom_range(1, 2);
        ml[d] = u;
        for (int i = d - 1; i >= 1; i--) begin
            tr[i] = $urandom_range(0, 1);
            ml[i] = 1 + ml[i+1] + tr[i];
        end
        for (int i = 1; i <= d; i++) prog[p++] = e_push(ml[i], $urandom_range(0, 3));
        for (int k = 0; k < u; k++)
            prog[p++] = e_upd($urandom_range(0, 5), $urandom_range(0, 7), $urandom_range(0, 7),
                              $urandom_range(0, 1), $urandom_range(0, 1));
        for (int i = d - 1; i >= 1; i--)
            if (tr[i] == 1)
                prog[p++] = e_upd($urandom_range(0, 5), $urandom_range(0, 7), $urandom_range(0, 7),
                                  $urandom_range(0, 1), $urandom_range(0, 1));
        prog[p++] = e_halt();
    endtask

    initial begin
        #(CLK_P * 190000);
        n_cmp++; n_bad++;
        $display("FAIL R8 global watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) mregs[i] = '0;
        mbrw = 6;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 idle after reset", busy, 0);
        check(lifo_empty, "R1 lifo_empty", lifo_empty, 1);
        check(!lifo_err && !addr_vld, "R1 err/vld low", lifo_err, 0);
        check(addr_o == 16'd0, "R1 addr_o", addr_o, 0);

        // R3 R4 R5 R6: directed operations, wrap ends and reverse
        clear_prog();
        prog[0] = e_ldi(6, 10);  prog[1] = e_ldi(7, 4);  prog[2] = e_ldi(0, 13);
        prog[3] = e_upd(0, 0, 2, 1, 0);      // 13+1 wraps to 10
        prog[4] = e_upd(0, 0, 4, 1, 0);      // 10-1 wraps to 13
        prog[5] = 16'h0000;                  // NOP
        prog[6] = e_cfg(3);  prog[7] = e_ldi(1, 1);
        prog[8] = e_upd(1, 0, 0, 0, 1);      // 1 mirrored over 3 bits = 4
        prog[9] = e_upd(1, 0, 2, 0, 0);      // stored value stayed 1 -> 2
        prog[10] = e_ldi(2, 5); prog[11] = e_ldi(3, 3);
        prog[12] = e_upd(2, 3, 1, 0, 0);     // 8
        prog[13] = e_upd(2, 3, 3, 0, 0);     // 5
        prog[14] = e_cfg(0);
        prog[15] = e_upd(2, 0, 0, 0, 1);     // width 1: 5 unchanged
        prog[16] = e_halt();
        load(); iss(); run(1'b0);
        compare("ops");
        check(got_addr[0] == 16'd10, "R5 wrap above", got_addr[0], 10);
        check(got_addr[1] == 16'd13, "R5 wrap below", got_addr[1], 13);
        check(got_addr[2] == 16'd4, "R6 reverse 3 bits", got_addr[2], 4);
        check(got_addr[3] == 16'd2, "R6 register unreversed", got_addr[3], 2);
        check(got_addr[4] == 16'd8 && got_addr[5] == 16'd5, "R4 add/sub", got_addr[4], 8);
        check(got_addr[6] == 16'd5, "R6 width 0 acts as 1", got_addr[6], 5);
        check(got_cyc == 17, "R3 NOP costs one cycle", got_cyc, 17);

        // R7 R9: shared end, inner count 3 outer count 2
        clear_prog();
        prog[0] = e_push(2, 2); prog[1] = e_push(1, 3);
        prog[2] = e_upd(0, 0, 2, 0, 0); prog[3] = e_halt();
        load(); iss(); run(1'b0);
        compare("shared");
        check(got_n == 6, "R9 cascade address count", got_n, 6);
        check(got_cyc == 10, "R8 zero overhead cycles", got_cyc, 10);
        check(lifo_empty, "R11 empty after loops", lifo_empty, 1);

        // R10: fifth push overflows, four loops close together
        clear_prog();
        prog[0] = e_push(5, 1); prog[1] = e_push(4, 1); prog[2] = e_push(3, 1);
        prog[3] = e_push(2, 1); prog[4] = e_push(1, 2);
        prog[5] = e_upd(0, 0, 2, 0, 0); prog[6] = e_halt();
        load(); iss(); run(1'b0);
        compare("ovf");
        check(lifo_err, "R10 overflow flagged", lifo_err, 1);
        check(got_n == 1, "R10 ignored push", got_n, 1);
        check(lifo_empty, "R11 empty after cascade", lifo_empty, 1);

        // R7 count zero acts as one; R10 cleared by start; R2 start ignored mid-run
        clear_prog();
        prog[0] = e_push(1, 0); prog[1] = e_upd(1, 0, 2, 0, 0);
        prog[2] = e_push(2, 5); prog[3] = e_upd(1, 0, 2, 0, 0); prog[4] = e_upd(0, 0, 4, 0, 0);
        prog[5] = e_halt();
        load(); iss(); run(1'b1);
        compare("zero");
        check(!lifo_err, "R10 cleared by start", lifo_err, 0);
        check(got_n == 11, "R7 count zero once", got_n, 11);
        check(got_cyc == 14, "R2 start ignored while busy", got_cyc, 14);

        // random nested programs
        for (int t = 0; t < 12; t++) begin
            gen_random();
            load(); iss(); run(1'b0);
            compare("rand R9");
            check(lifo_empty, "R11 empty at end", lifo_empty, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule